// File: doc/BRIEF.md
# Serial EEPROM Station-Address Loader

This block drives a four-wire serial EEPROM of 64 sixteen-bit words and fetches the station (MAC) address for a network interface. A single `start` pulse makes it read sixteen words, one complete chip-select frame per word, and turn them into a 32-byte image. Each word splits into two bytes, with the high byte placed at the even image position.

While the image arrives, an XOR sum runs over a parameterised span of bytes. At the end this sum is compared against a stored checksum byte. Six consecutive image bytes form the station address. The address is flagged valid only when the sum matches. Otherwise a checksum-error flag is raised.

Every pin phase is stretched to `DELAY_CYCLES` system clocks so that a fast core clock can meet the slow timing of the memory. A `busy` level and a one-cycle `done` pulse frame each load. Writing, erasing and write-enabling the memory are not supported.

Top module: `eeprom_mac_loader`

## Requirements
- R1: After reset, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done`, `addr_valid` and `cksum_err` are all low.
- R2: A load issues 16 frames for word addresses 0 to 15 in ascending order. Each frame shifts nine bits on `ee_di`, MSB first: start bit 1, opcode 1 then 0, then the 6-bit address. Each bit is set while `ee_sk` is low and held while `ee_sk` is high.
- R3: After the last address bit, `ee_sk` stays low for one phase with `ee_cs` high; this is a dummy slot that yields no data. Then 16 data clocks follow, with `ee_do` sampled after each falling edge, MSB first. Bits 15..8 become image byte 2·n and bits 7..0 become byte 2·n+1. A frame therefore carries exactly 25 rising edges of `ee_sk`.
- R4: When a frame ends, `ee_sk` and `ee_di` are low as `ee_cs` falls. `ee_cs` then stays low for at least one full phase before the next frame, and all three lines are low after the load.
- R5: Every high pulse of `ee_sk` lasts exactly `DELAY_CYCLES` clocks.
- R6: The loader XORs image bytes from `KEY_IDX` up to `CHK_IDX-1`, with defaults 0 and 31. If the result equals byte `CHK_IDX`, `addr_valid` goes to 1 and `cksum_err` to 0.
- R7: If the checksum does not match, `cksum_err` goes to 1 and `addr_valid` stays 0.
- R8: `station_addr` holds image bytes `SA_IDX` to `SA_IDX+5` (default 16). Byte `SA_IDX` sits in bits 47:40 and the rest follow in descending bit order.
- R9: A `start` that arrives while `busy` is high has no effect. The load still makes exactly 16 frames and ends with a single `done`.
- R10: `done` is high for exactly one cycle. In that cycle `busy` is low and the flags carry the verdict. An accepted `start` raises `busy` and clears both flags in the same cycle.
- R11: `ee_sk` is never high while `ee_cs` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a load when idle |
| busy | output | 1 | High while a load is in progress |
| done | output | 1 | One-cycle pulse when the verdict is ready |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data toward the memory |
| ee_do | input | 1 | Serial data from the memory (synchronised inside) |
| station_addr | output | 48 | Six-byte station address, first byte in the top bits |
| addr_valid | output | 1 | Address is valid (checksum matched) |
| cksum_err | output | 1 | Checksum mismatch |

## Verification
The hardest case to reach is a `start` that arrives in the middle of a load. It must leave the word sequence, the frame count and the single `done` untouched. The bench raises `start` again several hundred cycles into a load, then counts the memory frames and the `done` pulses of that run. The dummy slot is another subtle point: a loader that treated it as a data bit would shift every byte by one position. A behavioural memory model places a zero in that slot and real data after it, so any misalignment shows up as a wrong checksum verdict and a wrong address.

// File: rtl/mw_loader_pkg.sv
package mw_loader_pkg;
  typedef enum logic [2:0] {
    WR_IDLE, WR_LOW, WR_CMD_SET, WR_CMD_CLK, WR_ACK, WR_DAT_HI, WR_DAT_LO
  } wr_state_e;

  typedef enum logic [1:0] {
    LD_IDLE, LD_READ, LD_FINISH
  } ld_state_e;

  // start bit followed by the read opcode
  localparam logic [2:0] MW_READ_CMD = 3'b110;
endpackage

// File: rtl/mw_phase_timer.sv
module mw_phase_timer #(
  parameter int DELAY_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = $clog2(DELAY_CYCLES) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == LAST);

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/mw_word_reader.sv
module mw_word_reader
  import mw_loader_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr,
  input  logic              tick,
  output logic              timer_run,
  output logic              cs,
  output logic              sk,
  output logic              di,
  input  logic              dout_in,
  output logic [WORD_W-1:0] word,
  output logic              word_done
);
  localparam int CMD_W = 3 + ADDR_W;
  localparam int MAXB  = (CMD_W > WORD_W) ? CMD_W : WORD_W;
  localparam int BIT_W = $clog2(MAXB);

  wr_state_e         state;
  logic [BIT_W-1:0]  bitc;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] shreg;
  logic [CMD_W-1:0]  cmd;
  logic              do_s1, do_s2;
  logic              cs_c, sk_c, di_c;

  assign cmd       = {MW_READ_CMD, addr_q};
  assign timer_run = (state != WR_IDLE);
  assign word      = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      do_s1 <= 1'b0;
      do_s2 <= 1'b0;
    end else begin
      do_s1 <= dout_in;
      do_s2 <= do_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= WR_IDLE;
      bitc      <= '0;
      addr_q    <= '0;
      shreg     <= '0;
      word_done <= 1'b0;
    end else begin
      word_done <= 1'b0;
      unique case (state)
        WR_IDLE: if (go) begin
          addr_q <= addr;
          state  <= WR_LOW;
        end
        WR_LOW: if (tick) begin
          bitc  <= BIT_W'(CMD_W - 1);
          state <= WR_CMD_SET;
        end
        WR_CMD_SET: if (tick) state <= WR_CMD_CLK;
        WR_CMD_CLK: if (tick) begin
          if (bitc == '0) state <= WR_ACK;
          else begin
            bitc  <= bitc - 1'b1;
            state <= WR_CMD_SET;
          end
        end
        WR_ACK: if (tick) begin
          bitc  <= BIT_W'(WORD_W - 1);
          state <= WR_DAT_HI;
        end
        WR_DAT_HI: if (tick) state <= WR_DAT_LO;
        WR_DAT_LO: if (tick) begin
          shreg <= {shreg[WORD_W-2:0], do_s2};
          if (bitc == '0) begin
            state     <= WR_IDLE;
            word_done <= 1'b1;
          end else begin
            bitc  <= bitc - 1'b1;
            state <= WR_DAT_HI;
          end
        end
        default: state <= WR_IDLE;
      endcase
    end
  end

  always_comb begin
    cs_c = 1'b0;
    sk_c = 1'b0;
    di_c = 1'b0;
    unique case (state)
      WR_CMD_SET: begin cs_c = 1'b1; di_c = cmd[bitc]; end
      WR_CMD_CLK: begin cs_c = 1'b1; sk_c = 1'b1; di_c = cmd[bitc]; end
      WR_ACK:     cs_c = 1'b1;
      WR_DAT_HI:  begin cs_c = 1'b1; sk_c = 1'b1; end
      WR_DAT_LO:  cs_c = 1'b1;
      default:    ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs <= 1'b0;
      sk <= 1'b0;
      di <= 1'b0;
    end else begin
      cs <= cs_c;
      sk <= sk_c;
      di <= di_c;
    end
  end

  // R11
  sk_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    sk |-> cs);
  // R2
  di_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sk && $past(sk)) |-> $stable(di));
endmodule

// File: rtl/mw_image_check.sv
module mw_image_check #(
  parameter int IDX_W    = 5,
  parameter int WORD_W   = 16,
  parameter int KEY_IDX  = 0,
  parameter int CHK_IDX  = 31,
  parameter int SA_IDX   = 16,
  parameter int SA_BYTES = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  wr,
  input  logic [IDX_W-1:0]      base,
  input  logic [WORD_W-1:0]     word,
  output logic                  match,
  output logic [SA_BYTES*8-1:0] sa
);
  localparam int LANES = WORD_W / 8;

  logic [7:0] lane_d [LANES];
  int         lane_i [LANES];
  logic [7:0] sum_q, sum_n, stored_q, stored_n;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      lane_d[l] = word[(LANES-1-l)*8 +: 8];
      lane_i[l] = int'(base) + l;
    end
  end

  always_comb begin
    sum_n    = sum_q;
    stored_n = stored_q;
    for (int l = 0; l < LANES; l++) begin
      if (lane_i[l] >= KEY_IDX && lane_i[l] < CHK_IDX) sum_n = sum_n ^ lane_d[l];
      if (lane_i[l] == CHK_IDX) stored_n = lane_d[l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sum_q    <= '0;
      stored_q <= '0;
    end else if (wr) begin
      sum_q    <= sum_n;
      stored_q <= stored_n;
    end
  end

  assign match = (sum_q == stored_q);

  for (genvar k = 0; k < SA_BYTES; k++) begin : g_sa
    logic [7:0] b_q;
    always_ff @(posedge clk) begin
      if (rst || clr) b_q <= '0;
      else if (wr) begin
        for (int l = 0; l < LANES; l++)
          if (lane_i[l] == SA_IDX + k) b_q <= lane_d[l];
      end
    end
    assign sa[(SA_BYTES-1-k)*8 +: 8] = b_q;
  end
endmodule

// File: rtl/eeprom_mac_loader.sv
module eeprom_mac_loader
  import mw_loader_pkg::*;
#(
  parameter int DELAY_CYCLES = 4,
  parameter int WORD_COUNT   = 16,
  parameter int ADDR_W       = 6,
  parameter int KEY_IDX      = 0,
  parameter int CHK_IDX      = 31,
  parameter int SA_IDX       = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do,
  output logic [47:0] station_addr,
  output logic        addr_valid,
  output logic        cksum_err
);
  localparam int WORD_W    = 16;
  localparam int SA_BYTES  = 6;
  localparam int IMG_BYTES = WORD_COUNT * WORD_W / 8;
  localparam int IDX_W     = $clog2(IMG_BYTES);
  localparam int WIDX_W    = IDX_W - 1;
  localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(WORD_COUNT - 1);

  ld_state_e          state;
  logic [WIDX_W-1:0]  widx;
  logic               go, tick, run, word_done, match, clr, wr;
  logic [WORD_W-1:0]  word;
  logic [SA_BYTES*8-1:0] sa;

  mw_phase_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .run(run), .tick(tick));

  mw_word_reader #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_reader (
    .clk(clk), .rst(rst), .go(go), .addr(ADDR_W'(widx)), .tick(tick),
    .timer_run(run), .cs(ee_cs), .sk(ee_sk), .di(ee_di), .dout_in(ee_do),
    .word(word), .word_done(word_done));

  assign clr = (state == LD_IDLE) && start;
  assign wr  = (state == LD_READ) && word_done;

  mw_image_check #(.IDX_W(IDX_W), .WORD_W(WORD_W), .KEY_IDX(KEY_IDX),
    .CHK_IDX(CHK_IDX), .SA_IDX(SA_IDX), .SA_BYTES(SA_BYTES)) u_check (
    .clk(clk), .rst(rst), .clr(clr), .wr(wr), .base({widx, 1'b0}),
    .word(word), .match(match), .sa(sa));

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= LD_IDLE;
      widx         <= '0;
      go           <= 1'b0;
      busy         <= 1'b0;
      done         <= 1'b0;
      addr_valid   <= 1'b0;
      cksum_err    <= 1'b0;
      station_addr <= '0;
    end else begin
      go   <= 1'b0;
      done <= 1'b0;
      unique case (state)
        LD_IDLE: if (start) begin
          busy       <= 1'b1;
          addr_valid <= 1'b0;
          cksum_err  <= 1'b0;
          widx       <= '0;
          go         <= 1'b1;
          state      <= LD_READ;
        end
        LD_READ: if (word_done) begin
          if (widx == LAST_W) state <= LD_FINISH;
          else begin
            widx <= widx + 1'b1;
            go   <= 1'b1;
          end
        end
        LD_FINISH: begin
          addr_valid   <= match;
          cksum_err    <= !match;
          station_addr <= sa;
          busy         <= 1'b0;
          done         <= 1'b1;
          state        <= LD_IDLE;
        end
        default: state <= LD_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R10
  flags_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (!addr_valid && !cksum_err));
  // R7
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(addr_valid && cksum_err));
endmodule

// File: tb/eeprom_mac_loader_test.sv
module eeprom_mac_loader_test;
  localparam int DLY = 3;

  typedef struct packed {
    logic        v;
    logic        e;
    logic [47:0] mac;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic busy, done, ee_cs, ee_sk, ee_di, addr_valid, cksum_err;
  logic ee_do_r = 1'b0;
  logic [47:0] station_addr;

  always #5 clk = ~clk;

  eeprom_mac_loader #(.DELAY_CYCLES(DLY)) uut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do_r),
    .station_addr(station_addr), .addr_valid(addr_valid), .cksum_err(cksum_err));

  int checks = 0, fails = 0, done_cnt = 0;
  bit finished = 0;
  logic [7:0] img [32];
  exp_t q[$];

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural serial memory
  int edges = 0, frames = 0, sk_hi = 0, cs_lo = 100;
  logic prev_cs = 0, prev_sk = 0;
  logic [8:0] cmdsh = '0;
  logic [15:0] dword = '0;

  always @(negedge clk) begin
    if (rst) begin
      edges = 0; prev_cs = 0; prev_sk = 0; sk_hi = 0; cs_lo = 100;
      ee_do_r <= 1'b0;
    end else begin
      if (ee_cs && !prev_cs) begin
        chk(cs_lo >= DLY, "R4 cs low gap", 64'(cs_lo), 64'(DLY));
        edges = 0;
      end
      if (!ee_sk && prev_sk)
        chk(sk_hi == DLY, "R5 sk high width", 64'(sk_hi), 64'(DLY));
      if (ee_sk && !prev_sk) begin
        edges++;
        if (edges <= 9) cmdsh = {cmdsh[7:0], ee_di};
        if (edges == 9) begin
          chk(cmdsh == {3'b110, 6'(frames % 16)}, "R2 read command",
              64'(cmdsh), 64'({3'b110, 6'(frames % 16)}));
          dword = {img[2*cmdsh[3:0]], img[2*cmdsh[3:0]+1]};
          ee_do_r <= 1'b0;
        end else if (edges >= 10 && edges <= 25) begin
          ee_do_r <= dword[25-edges];
        end
      end
      if (!ee_cs && prev_cs) begin
        chk(edges == 25, "R3 clocks per frame", 64'(edges), 64'd25);
        chk(!ee_sk && !ee_di, "R4 lines low at frame end", 64'({ee_sk, ee_di}), 64'd0);
        frames++;
        ee_do_r <= 1'b0;
      end
      sk_hi = ee_sk ? sk_hi + 1 : 0;
      cs_lo = ee_cs ? 0 : cs_lo + 1;
      prev_cs = ee_cs;
      prev_sk = ee_sk;
    end
  end

  // monitor: pops expected verdicts as done pulses appear
  always @(negedge clk) begin
    exp_t e;
    if (!rst && done) begin
      done_cnt++;
      if (q.size() == 0) chk(1'b0, "R9 unexpected done", 64'd1, 64'd0);
      else begin
        e = q.pop_front();
        chk(addr_valid == e.v, "R6 addr_valid", 64'(addr_valid), 64'(e.v));
        chk(cksum_err == e.e, "R7 cksum_err", 64'(cksum_err), 64'(e.e));
        if (e.v) chk(station_addr == e.mac, "R8 station address",
                     64'(station_addr), 64'(e.mac));
        chk(!busy, "R10 busy low at done", 64'(busy), 64'd0);
      end
    end
  end

  task automatic fill(int seed, bit good);
    logic [7:0] x = '0;
    for (int i = 0; i < 31; i++) begin
      img[i] = 8'(seed * 37 + i * 11 + i * i * seed);
      x ^= img[i];
    end
    img[31] = good ? x : (x ^ 8'h5A);
  endtask

  task automatic run_load(bit good, bit restart_mid);
    exp_t e;
    int f0 = frames;
    int d0 = done_cnt;
    e.v = good;
    e.e = !good;
    e.mac = {img[16], img[17], img[18], img[19], img[20], img[21]};
    q.push_back(e);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R10 busy after start", 64'(busy), 64'd1);
    chk(!addr_valid && !cksum_err, "R10 flags cleared on start",
        64'({addr_valid, cksum_err}), 64'd0);
    if (restart_mid) begin
      repeat (400) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(!done, "R10 done lasts one cycle", 64'(done), 64'd0);
    repeat (40) @(negedge clk);
    chk(frames - f0 == 16, "R9 frames per load", 64'(frames - f0), 64'd16);
    chk(done_cnt - d0 == 1, "R9 done count per load", 64'(done_cnt - d0), 64'd1);
    chk(!busy, "R9 idle after load", 64'(busy), 64'd0);
    chk(!ee_cs && !ee_sk && !ee_di, "R4 lines low after load",
        64'({ee_cs, ee_sk, ee_di}), 64'd0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!ee_cs && !ee_sk && !ee_di, "R1 pins after reset",
        64'({ee_cs, ee_sk, ee_di}), 64'd0);
    chk(!busy && !done, "R1 handshake after reset", 64'({busy, done}), 64'd0);
    chk(!addr_valid && !cksum_err, "R1 flags after reset",
        64'({addr_valid, cksum_err}), 64'd0);
    fill(1, 1'b1); run_load(1'b1, 1'b0);
    fill(2, 1'b0); run_load(1'b0, 1'b0);
    fill(3, 1'b1); run_load(1'b1, 1'b1);
    fill(5, 1'b0); run_load(1'b0, 1'b1);
    fill(7, 1'b1); run_load(1'b1, 1'b0);
    chk(q.size() == 0, "R10 all verdicts seen", 64'(q.size()), 64'd0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule